// File: doc/BRIEF.md
# Two-Dimensional DMA Address Generator

This block walks one DMA channel through a grid of memory addresses. A transfer is set up by a start address and by two (count, step) pairs. The inner pair describes the elements of a row, and the outer pair describes how the generator jumps from the end of one row to the start of the next. Steps are signed and counted in elements. The byte offset is the step shifted left by `ELEM_SHIFT`. Because the outer step may be smaller than the inner step, or negative, the generator can interleave or de-interleave streams held in one buffer.

A parameter set is presented on the load port, either from registers written directly or from a fetched parameter block. The generator then offers one address per beat on a valid/ready handshake. In one-shot mode it stops after the last element of the buffer. In circular mode it restarts at the start address by itself. It gives a one-cycle pulse at each buffer end and, when enabled, at each row end. These pulses serve as interrupt requests. An abort input stops the channel at any time.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `busy`, `addr_valid`, `row_done` and `buf_done` are all 0.
- R2: When the block is idle and `cfg_load` is high with `abort` low at a clock edge, `addr_valid` is 1 from the next cycle and `addr` equals `cfg_base`.
- R3: Within a row, each accepted beat (`addr_valid` and `addr_ready` both high) advances `addr` by the sign-extended `cfg_xstep` times 2^ELEM_SHIFT. While `addr_ready` is low, `addr` and `addr_valid` hold.
- R4: An accepted beat on the last element of a row advances `addr` by the sign-extended `cfg_ystep` times 2^ELEM_SHIFT, measured from that last element's address, and the row counter restarts. A negative outer step, or one smaller than the inner step, gives an interleaved order.
- R5: A count field of 0 (`cfg_xcount` or `cfg_ycount`) means 65536 elements or rows.
- R6: Address arithmetic wraps modulo 2^32.
- R7: In one-shot mode (`cfg_circular`=0), `addr_valid` and `busy` are 0 in the cycle after the final accepted beat of the buffer. `buf_done` is 1 for exactly that one cycle.
- R8: In circular mode (`cfg_circular`=1), the beat after the final element presents `cfg_base` again and `addr_valid` stays 1. `buf_done` pulses for one cycle after every pass.
- R9: With `cfg_row_irq`=1, `row_done` is 1 for the one cycle after each accepted last-of-row beat. With `cfg_row_irq`=0, `row_done` stays 0.
- R10: `cfg_load` while `busy`=1 has no effect on the address sequence, except in the case given in R12.
- R11: `abort` high at an edge makes `addr_valid` and `busy` 0 in the next cycle. An accepted beat at that same edge raises neither pulse. A following load starts a new transfer.
- R12: In circular mode, a `cfg_load` that coincides with the final accepted beat of a pass takes effect, and the next pass uses the new parameters.
- R13: With `cfg_2d`=0 the buffer is a single row of `cfg_xcount` elements, and `cfg_ycount` and `cfg_ystep` are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load the parameter set below |
| cfg_base | input | AW | Start address |
| cfg_xcount | input | CW | Elements per row, 0 means 2^CW |
| cfg_xstep | input | SW | Signed step between elements of a row |
| cfg_ycount | input | CW | Rows per buffer, 0 means 2^CW |
| cfg_ystep | input | SW | Signed step from the last element of a row to the next row |
| cfg_2d | input | 1 | 1: two-dimensional, 0: single row |
| cfg_circular | input | 1 | 1: auto-restart, 0: stop at the end |
| cfg_row_irq | input | 1 | Enable the row-end pulse |
| abort | input | 1 | Stop the current transfer |
| addr_valid | output | 1 | Address offered |
| addr_ready | input | 1 | Consumer accepts the address |
| addr | output | AW | Current byte address |
| busy | output | 1 | Transfer in progress |
| row_done | output | 1 | One-cycle pulse after a row's last beat |
| buf_done | output | 1 | One-cycle pulse after a buffer's last beat |

## Verification
A corrupted element or row counter shows as a wrong address on the very next accepted beat at a row boundary. It also moves `row_done` or `buf_done` away from its predicted cycle, and in one-shot mode `addr_valid` drops early or late. A wrong stored step or base appears at the first beat that uses it, which is at most one row into the buffer, or at the restart of a circular pass. Every offered address is compared against a closed-form position formula, so any divergence surfaces in the cycle it occurs rather than at the end of the transfer.

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int SW = 16,
  parameter int ELEM_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_base,
  input  logic [CW-1:0] cfg_xcount,
  input  logic [SW-1:0] cfg_xstep,
  input  logic [CW-1:0] cfg_ycount,
  input  logic [SW-1:0] cfg_ystep,
  input  logic          cfg_2d,
  input  logic          cfg_circular,
  input  logic          cfg_row_irq,
  input  logic          abort,
  output logic          addr_valid,
  input  logic          addr_ready,
  output logic [AW-1:0] addr,
  output logic          busy,
  output logic          row_done,
  output logic          buf_done
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int RW = CW + 1;

  function automatic logic [RW-1:0] span(input logic [CW-1:0] n);
    return (n == '0) ? (RW'(1) << CW) : RW'(n);
  endfunction

  function automatic logic [AW-1:0] stride(input logic [SW-1:0] s);
    return {{(AW-SW){s[SW-1]}}, s} << ELEM_SHIFT;
  endfunction

  logic [AW-1:0] base_q, addr_q;
  logic [SW-1:0] xstep_q, ystep_q;
  logic [RW-1:0] xspan_q, yspan_q, xrem_q, yrem_q;
  logic          circ_q, rowirq_q, busy_q, row_q, buf_q;

  logic fire, row_end, buf_end, take;
  assign fire    = busy_q & addr_ready;
  assign row_end = fire & (xrem_q == RW'(1));
  assign buf_end = row_end & (yrem_q == RW'(1));
  assign take    = cfg_load & ~abort & (~busy_q | (circ_q & buf_end));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q   <= '0;
      addr_q   <= '0;
      xstep_q  <= '0;
      ystep_q  <= '0;
      xspan_q  <= '0;
      yspan_q  <= '0;
      xrem_q   <= '0;
      yrem_q   <= '0;
      circ_q   <= 1'b0;
      rowirq_q <= 1'b0;
      busy_q   <= 1'b0;
      row_q    <= 1'b0;
      buf_q    <= 1'b0;
    end else begin
      row_q <= row_end & rowirq_q & ~abort;
      buf_q <= buf_end & ~abort;
      if (abort) begin
        busy_q <= 1'b0;
      end else if (take) begin
        base_q   <= cfg_base;
        addr_q   <= cfg_base;
        xstep_q  <= cfg_xstep;
        ystep_q  <= cfg_ystep;
        xspan_q  <= span(cfg_xcount);
        yspan_q  <= cfg_2d ? span(cfg_ycount) : RW'(1);
        xrem_q   <= span(cfg_xcount);
        yrem_q   <= cfg_2d ? span(cfg_ycount) : RW'(1);
        circ_q   <= cfg_circular;
        rowirq_q <= cfg_row_irq;
        busy_q   <= 1'b1;
      end else if (buf_end) begin
        if (circ_q) begin
          addr_q <= base_q;
          xrem_q <= xspan_q;
          yrem_q <= yspan_q;
        end else begin
          busy_q <= 1'b0;
        end
      end else if (row_end) begin
        addr_q <= addr_q + stride(ystep_q);
        xrem_q <= xspan_q;
        yrem_q <= yrem_q - RW'(1);
      end else if (fire) begin
        addr_q <= addr_q + stride(xstep_q);
        xrem_q <= xrem_q - RW'(1);
      end
    end
  end

  assign addr_valid = busy_q;
  assign busy       = busy_q;
  assign addr       = addr_q;
  assign row_done   = row_q;
  assign buf_done   = buf_q;
endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic [AW-1:0] cfg_base,
  input logic          abort,
  input logic          addr_valid,
  input logic          addr_ready,
  input logic [AW-1:0] addr,
  input logic          row_done,
  input logic          buf_done
);
  timeunit 1ns;
  timeprecision 1ps;

  assert_start_at_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_valid && cfg_load && !abort) |=> (addr_valid && addr == $past(cfg_base)));

  assert_hold_when_stalled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !addr_ready && !abort) |=> (addr_valid && $stable(addr)));

  assert_buf_pulse_after_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_done |-> $past(addr_valid && addr_ready && !abort));

  assert_row_pulse_after_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> $past(addr_valid && addr_ready && !abort));

  assert_abort_quiets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!addr_valid && !row_done && !buf_done));
endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
  .abort(abort), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .addr(addr), .row_done(row_done), .buf_done(buf_done)
);

// File: tb/test_dma2d_addr_gen.sv
module test_dma2d_addr_gen;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_load = 0, cfg_2d = 0, cfg_circular = 0, cfg_row_irq = 0, abort = 0;
  logic [31:0] cfg_base = '0;
  logic [15:0] cfg_xcount = '0, cfg_xstep = '0, cfg_ycount = '0, cfg_ystep = '0;
  logic        addr_ready = 0;
  logic        addr_valid, busy, row_done, buf_done;
  logic [31:0] addr;
  int nvec = 0, nerr = 0;

  always #4 clk = ~clk;

  dma2d_addr_gen i_dma2d_addr_gen (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_base(cfg_base),
    .cfg_xcount(cfg_xcount), .cfg_xstep(cfg_xstep), .cfg_ycount(cfg_ycount),
    .cfg_ystep(cfg_ystep), .cfg_2d(cfg_2d), .cfg_circular(cfg_circular),
    .cfg_row_irq(cfg_row_irq), .abort(abort), .addr_valid(addr_valid),
    .addr_ready(addr_ready), .addr(addr), .busy(busy),
    .row_done(row_done), .buf_done(buf_done)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int eff(input logic [15:0] n);
    return (n == 16'd0) ? 65536 : int'(n);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input int xe, input int xs,
                                           input int ys, input int r, input int c);
    longint pitch = longint'(xe - 1) * xs + ys;
    longint off = longint'(r) * pitch + longint'(c) * xs;
    return b + 32'(off * 4);
  endfunction

  task automatic run(input logic [31:0] b, input logic [15:0] xc, input logic [15:0] xs,
                     input logic [15:0] yc, input logic [15:0] ys, input bit twod,
                     input bit circ, input bit rq, input int passes, input bit fast,
                     input bit junk, input bit swap, input logic [31:0] b2,
                     input logic [15:0] xc2, input logic [15:0] xs2, input string tag);
    int xe = eff(xc), ye = twod ? eff(yc) : 1;
    int mxs = int'($signed(xs)), mys = int'($signed(ys));
    logic [31:0] mb = b;
    int r = 0, c = 0, pass = 0;
    bit er = 0, eb = 0, fin = 0, rdy, lastc, lastb;
    cfg_base = b; cfg_xcount = xc; cfg_xstep = xs; cfg_ycount = yc; cfg_ystep = ys;
    cfg_2d = twod; cfg_circular = circ; cfg_row_irq = rq; cfg_load = 1;
    forever begin
      @(negedge clk);
      cfg_load = 0;
      chk(row_done === er, {tag, " R9 row_done"}, 32'(row_done), 32'(er));
      chk(buf_done === eb, {tag, " R7/R8 buf_done"}, 32'(buf_done), 32'(eb));
      if (fin) begin
        chk(addr_valid === 1'b0 && busy === 1'b0, {tag, " R7 stop"}, 32'(addr_valid), 0);
        break;
      end
      chk(addr_valid === 1'b1, {tag, " R2/R8 valid"}, 32'(addr_valid), 1);
      chk(addr === exp_addr(mb, xe, mxs, mys, r, c), {tag, " R3/R4 addr"}, addr,
          exp_addr(mb, xe, mxs, mys, r, c));
      er = 0; eb = 0;
      if (circ && pass == passes) begin
        abort = 1; addr_ready = 1;
        @(negedge clk);
        abort = 0; addr_ready = 0;
        chk(addr_valid === 1'b0 && busy === 1'b0, {tag, " R11 abort stop"}, 32'(addr_valid), 0);
        chk(row_done === 1'b0 && buf_done === 1'b0, {tag, " R11 no pulse"},
            32'({row_done, buf_done}), 0);
        break;
      end
      rdy = fast || ($urandom % 4 != 0);
      addr_ready = rdy;
      lastc = (c == xe - 1);
      lastb = lastc && (r == ye - 1);
      if (junk && !lastb && ($urandom % 6 == 0)) begin
        cfg_base = $urandom; cfg_xcount = 16'($urandom); cfg_xstep = 16'($urandom);
        cfg_ycount = 16'($urandom); cfg_ystep = 16'($urandom);
        cfg_2d = 1'($urandom); cfg_circular = 1'($urandom); cfg_load = 1;
      end
      if (rdy) begin
        if (lastc) begin
          er = rq; c = 0;
          if (lastb) begin
            eb = 1; r = 0; pass++;
            if (!circ) fin = 1;
            else if (swap && pass == 1) begin
              cfg_base = b2; cfg_xcount = xc2; cfg_xstep = xs2; cfg_2d = 0;
              cfg_circular = 1; cfg_row_irq = rq; cfg_load = 1;
              mb = b2; xe = eff(xc2); mxs = int'($signed(xs2)); ye = 1;
            end
          end else r++;
        end else c++;
      end
    end
    addr_ready = 0; cfg_load = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(busy === 0 && addr_valid === 0 && row_done === 0 && buf_done === 0,
        "R1 reset state", 32'({busy, addr_valid, row_done, buf_done}), 0);
    rst_n = 1;
    @(negedge clk);
    // R13 single row ignores outer fields; R10 junk loads mid-transfer
    run(32'h0000_1000, 16'd8, 16'd1, 16'd7, 16'd100, 0, 0, 1, 1, 0, 1, 0, 0, 0, 0, "R13 1d");
    // R4 interleave: outer step negative and smaller than inner
    run(32'h0002_0000, 16'd4, 16'd3, 16'd3, 16'hFFF8, 1, 0, 1, 1, 0, 0, 0, 0, 0, 0, "R4 ilv");
    for (int i = 0; i < 20; i++)
      run($urandom, 16'(1 + $urandom % 6), 16'($urandom), 16'(1 + $urandom % 5),
          16'($urandom), 1, 0, 1'($urandom), 1, 0, 1, 0, 0, 0, 0, "R4 rand2d");
    // R6 wrap past the top of the address space
    run(32'hFFFF_FFF0, 16'd10, 16'd1, 16'd0, 16'd0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R6 wrap");
    // R8 circular 2-D, three passes then abort
    run(32'h0040_0000, 16'd3, 16'd2, 16'd2, 16'd5, 1, 1, 1, 3, 0, 1, 0, 0, 0, 0, "R8 circ");
    // R11 abort on a final beat of one-element circular buffer
    run(32'h0000_0800, 16'd1, 16'd1, 16'd0, 16'd0, 0, 1, 0, 4, 0, 0, 0, 0, 0, 0, "R11 circ1");
    // R12 parameter swap at end of first circular pass
    run(32'h0010_0000, 16'd3, 16'd1, 16'd2, 16'd4, 1, 1, 1, 3, 0, 0, 1,
        32'h0030_0100, 16'd5, 16'hFFFF, "R12 swap");
    // R5 count of zero means 65536 elements
    run(32'h0000_0000, 16'd0, 16'd1, 16'd0, 16'd0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0, "R5 zero");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule